// File: doc/BRIEF.md
# Multiplexed External Memory Bus Interface

This block sits between a processor core and a narrow external memory bus. The core hands it one access at a time: a code fetch, a data read or a data write. The block runs each access over one machine cycle of twelve oscillator clocks. Every external access starts the same way. One 8-bit port carries the low address byte while an address-latch strobe is high. The strobe then falls, and an external latch keeps that byte. After that the same port carries the data. A second port holds the high address byte for the whole access. Code reads and data reads use different active-low strobes, so the code space and the data space are two separate 64K spaces. Data writes have their own active-low strobe.

Code fetches to the bottom 4K of code addresses can be served from an on-chip ROM. The external-access input selects this at the moment the request is accepted. When it is high, those fetches go to the ROM port and the external bus stays quiet. When it is low, every code fetch goes out on the bus. Data accesses always go to the external bus, whatever the external-access input says.

Top module: `ext_mem_bus`

## Requirements
- R1: While rst_ni is low, psen_no, rd_no and wr_no are high, ale_o and ad_oe_o are low, and ready_o is high once the reset has been applied.
- R2: An external access raises ale_o for phases 0 and 1 of its machine cycle. During those phases ad_o drives address bits 7..0 with ad_oe_o high. ale_o falls at phase 2, while the low address is still driven.
- R3: During every phase of an external access in which ale_o or a strobe is active, addr_hi_o carries address bits 15..8.
- R4: An external code fetch (kind_i = 0) holds psen_no low for six clocks, phases 4 to 9. Over the same clocks rd_no and wr_no stay high. The byte on ad_i in phase 9 is returned on rdata_o together with done_o.
- R5: A data read (kind_i = 1) holds rd_no low for phases 4 to 9, with ad_oe_o low throughout. The byte on ad_i in phase 9 is returned on rdata_o with done_o.
- R6: A data write (kind_i = 2) drives wdata_i on ad_o from phase 3 to phase 10. wr_no is low for phases 4 to 9, so a memory that captures on the rising edge of wr_no stores wdata_i.
- R7: At most one of psen_no, rd_no and wr_no is low at any clock.
- R8: A code fetch with ea_i high and an address below 4096 makes no bus activity. ale_o and all strobes stay inactive. rom_en_o is high for phases 4 to 9, rom_addr_o carries address bits 11..0, and rom_data_i from phase 9 is returned on rdata_o.
- R9: A code fetch goes to the external bus when ea_i is low, and also when ea_i is high and the address is 4096 or above.
- R10: A request is accepted on a rising edge where req_i and ready_o are both high. ready_o is then low for the twelve clocks of the machine cycle, and done_o is high in the twelfth of them.
- R11: Data reads and writes go to the external bus for any address, including addresses below 4096 with ea_i high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request from the core |
| kind_i | input | 2 | 0 code fetch, 1 data read, 2 data write |
| addr_i | input | 16 | Access address |
| wdata_i | input | 8 | Write data |
| ea_i | input | 1 | High: low 4K of code is served on chip |
| ready_o | output | 1 | Block idle, can accept a request |
| done_o | output | 1 | Last clock of the access, rdata_o valid for reads |
| rdata_o | output | 8 | Read result |
| ad_o | output | 8 | Low address / data out, multiplexed |
| ad_oe_o | output | 1 | Output enable for ad_o |
| ad_i | input | 8 | Data in from the multiplexed port |
| addr_hi_o | output | 8 | High address byte |
| ale_o | output | 1 | Address latch strobe, active high |
| psen_no | output | 1 | Code read strobe, active low |
| rd_no | output | 1 | Data read strobe, active low |
| wr_no | output | 1 | Data write strobe, active low |
| rom_en_o | output | 1 | On-chip ROM read enable |
| rom_addr_o | output | 12 | On-chip ROM address |
| rom_data_i | input | 8 | On-chip ROM data |

## Verification
The assertions assume the core issues only kind codes 0, 1 and 2. They also assume that addr_i, wdata_i, kind_i and ea_i are stable on the accepting edge, and that external memory returns data on ad_i by phase 9 of the strobe window. The bench drives a request only when ready_o is high and uses only the three defined kind codes. Its memory models answer ad_i as soon as the relevant strobe goes low, so every sample falls inside the window the design assumes.

// File: rtl/ext_bus_pkg.sv
package ext_bus_pkg;
  typedef enum logic [1:0] {
    ACC_CODE = 2'd0,
    ACC_RD   = 2'd1,
    ACC_WR   = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/ext_bus_phase.sv
module ext_bus_phase #(
  parameter int CYCLE_CLKS = 12,
  localparam int PW = $clog2(CYCLE_CLKS),
  localparam int LAST = CYCLE_CLKS - 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          active_o,
  output logic [PW-1:0] ph_o
);
  logic          active_q;
  logic [PW-1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      ph_q     <= '0;
    end else if (!active_q) begin
      if (start_i) begin
        active_q <= 1'b1;
        ph_q     <= '0;
      end
    end else if (ph_q == PW'(LAST)) begin
      active_q <= 1'b0;
      ph_q     <= '0;
    end else begin
      ph_q <= ph_q + 1'b1;
    end
  end

  assign active_o = active_q;
  assign ph_o     = ph_q;

  assert_phase_range_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> ph_q <= PW'(LAST));
  assert_cycle_full_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && ph_q != PW'(LAST)) |=> active_q);
endmodule

// File: rtl/ext_bus_req.sv
module ext_bus_req
  import ext_bus_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int ROM_SIZE = 4096
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          take_i,
  input  logic [1:0]    kind_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          ea_i,
  output acc_kind_e     kind_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic          intl_o
);
  acc_kind_e     kind_d, kind_q;
  logic          hit;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          intl_q;

  always_comb begin
    case (kind_i)
      2'd0:    kind_d = ACC_CODE;
      2'd2:    kind_d = ACC_WR;
      default: kind_d = ACC_RD;
    endcase
  end

  generate
    if (ROM_SIZE > 0) begin : g_rom
      assign hit = (kind_d == ACC_CODE) && ea_i && (addr_i < AW'(ROM_SIZE));
    end else begin : g_no_rom
      assign hit = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q  <= ACC_CODE;
      addr_q  <= '0;
      wdata_q <= '0;
      intl_q  <= 1'b0;
    end else if (take_i) begin
      kind_q  <= kind_d;
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
      intl_q  <= hit;
    end
  end

  assign kind_o  = kind_q;
  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;
  assign intl_o  = intl_q;

  assert_data_never_rom_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_q != ACC_CODE) |-> !intl_q);
endmodule

// File: rtl/ext_bus_strobes.sv
module ext_bus_strobes
  import ext_bus_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int CYCLE_CLKS = 12,
  localparam int PW = $clog2(CYCLE_CLKS),
  localparam int HW = AW - DW,
  localparam int ALE_END = 2,
  localparam int ADDR_END = 3,
  localparam int STB_BEG = 4,
  localparam int STB_END = CYCLE_CLKS - 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          active_i,
  input  logic [PW-1:0] ph_i,
  input  acc_kind_e     kind_i,
  input  logic          intl_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] ad_o,
  output logic          ad_oe_o,
  output logic [HW-1:0] addr_hi_o,
  output logic          ale_o,
  output logic          psen_no,
  output logic          rd_no,
  output logic          wr_no,
  output logic          rom_en_o
);
  logic ext, in_ale, in_addr, in_stb, in_wdat, wr_acc;

  assign ext     = active_i && !intl_i;
  assign in_ale  = ph_i < PW'(ALE_END);
  assign in_addr = ph_i < PW'(ADDR_END);
  assign in_stb  = (ph_i >= PW'(STB_BEG)) && (ph_i < PW'(STB_END));
  assign in_wdat = (ph_i >= PW'(ADDR_END)) && (ph_i <= PW'(STB_END));
  assign wr_acc  = kind_i == ACC_WR;

  assign ale_o     = ext && in_ale;
  assign ad_oe_o   = ext && (in_addr || (wr_acc && in_wdat));
  assign ad_o      = !ext ? '0 : in_addr ? addr_i[DW-1:0] :
                     (wr_acc && in_wdat) ? wdata_i : '0;
  assign addr_hi_o = ext ? addr_i[AW-1:DW] : '0;
  assign psen_no   = !(ext && kind_i == ACC_CODE && in_stb);
  assign rd_no     = !(ext && kind_i == ACC_RD && in_stb);
  assign wr_no     = !(ext && wr_acc && in_stb);
  assign rom_en_o  = active_i && intl_i && in_stb;

  // latch closes on a held address
  assert_ale_fall_addr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ale_o) |-> ad_oe_o && $stable(ad_o));
  assert_ale_drives_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> ad_oe_o);
  assert_read_released_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_no || !psen_no) |-> !ad_oe_o);
  assert_wdata_setup_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wr_no) |-> ad_oe_o && $stable(ad_o));
  assert_wdata_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_no) |-> ad_oe_o && $stable(ad_o));
  assert_rom_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_en_o |-> psen_no && rd_no && wr_no && !ale_o);
endmodule

// File: rtl/ext_mem_bus.sv
module ext_mem_bus
  import ext_bus_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int CYCLE_CLKS = 12,
  parameter int ROM_SIZE = 4096,
  localparam int HW = AW - DW,
  localparam int PW = $clog2(CYCLE_CLKS),
  localparam int ROM_AW = (ROM_SIZE > 1) ? $clog2(ROM_SIZE) : 1,
  localparam int SAMPLE = CYCLE_CLKS - 3,
  localparam int LAST = CYCLE_CLKS - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [1:0]        kind_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              ea_i,
  output logic              ready_o,
  output logic              done_o,
  output logic [DW-1:0]     rdata_o,
  output logic [DW-1:0]     ad_o,
  output logic              ad_oe_o,
  input  logic [DW-1:0]     ad_i,
  output logic [HW-1:0]     addr_hi_o,
  output logic              ale_o,
  output logic              psen_no,
  output logic              rd_no,
  output logic              wr_no,
  output logic              rom_en_o,
  output logic [ROM_AW-1:0] rom_addr_o,
  input  logic [DW-1:0]     rom_data_i
);
  logic          active, take, intl;
  logic [PW-1:0] ph;
  acc_kind_e     kind;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata_q;

  assign take = req_i && !active;

  ext_bus_phase #(.CYCLE_CLKS(CYCLE_CLKS)) i_phase (
    .clk_i, .rst_ni, .start_i(take), .active_o(active), .ph_o(ph)
  );

  ext_bus_req #(.AW(AW), .DW(DW), .ROM_SIZE(ROM_SIZE)) i_req (
    .clk_i, .rst_ni, .take_i(take), .kind_i, .addr_i, .wdata_i, .ea_i,
    .kind_o(kind), .addr_o(addr), .wdata_o(wdata), .intl_o(intl)
  );

  ext_bus_strobes #(.AW(AW), .DW(DW), .CYCLE_CLKS(CYCLE_CLKS)) i_strobes (
    .clk_i, .rst_ni, .active_i(active), .ph_i(ph), .kind_i(kind), .intl_i(intl),
    .addr_i(addr), .wdata_i(wdata), .ad_o, .ad_oe_o, .addr_hi_o, .ale_o,
    .psen_no, .rd_no, .wr_no, .rom_en_o
  );

  // capture one clock before the strobe rises
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (active && ph == PW'(SAMPLE)) rdata_q <= intl ? rom_data_i : ad_i;
  end

  assign ready_o    = !active;
  assign done_o     = active && ph == PW'(LAST);
  assign rdata_o    = rdata_q;
  assign rom_addr_o = addr[ROM_AW-1:0];

  assert_reset_idle_R1: assert property (@(posedge clk_i)
    !rst_ni |-> psen_no && rd_no && wr_no && !ale_o && !ad_oe_o);
  assert_one_strobe_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({!psen_no, !rd_no, !wr_no}) <= 1);
  assert_accept_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o) |=> !ready_o);
  assert_done_frees_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> ready_o);
endmodule

// File: tb/test_ext_mem_bus.sv
module test_ext_mem_bus;
  localparam int PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b1;
  logic        req_i = 1'b0;
  logic [1:0]  kind_i = 2'd0;
  logic [15:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic        ea_i = 1'b0;
  logic        ready_o, done_o, ad_oe_o, ale_o, psen_no, rd_no, wr_no, rom_en_o;
  logic [7:0]  rdata_o, ad_o, ad_i, addr_hi_o, rom_data_i;
  logic [11:0] rom_addr_o;

  ext_mem_bus i_ext_mem_bus (.*);

  always #(PERIOD/2) clk_i = ~clk_i;

  typedef struct {
    logic [1:0]  kind;
    logic        intl;
    logic [15:0] addr;
    logic [7:0]  exp;
    int          start;
    string       tag;
  } item_t;

  item_t      q[$];
  logic [7:0] dmem [256];
  logic [7:0] shadow [256];
  logic [7:0] lat = '0;
  logic       started = 1'b0;
  int cyc = 0, n_cmp = 0, n_bad = 0;
  int c_psen = 0, c_rd = 0, c_wr = 0, c_ale = 0, c_rom = 0;
  int multi = 0, rd_drive = 0, hi_bad = 0, lo_bad = 0;

  function automatic logic [7:0] code_val(logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction
  function automatic logic [7:0] rom_val(logic [11:0] a);
    return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'hC3;
  endfunction

  // external latch and memories
  always @(negedge ale_o) lat = ad_o;
  always @(posedge wr_no) if (started) dmem[lat] = ad_o;
  assign ad_i = !psen_no ? code_val({addr_hi_o, lat}) : (!rd_no ? dmem[lat] : 8'hFF);
  assign rom_data_i = rom_val(rom_addr_o);

  always @(posedge clk_i) cyc++;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic issue(logic [1:0] k, logic [15:0] a, logic [7:0] wd, logic ea, string tag);
    item_t it;
    while (!ready_o) @(negedge clk_i);
    it.kind  = k;
    it.addr  = a;
    it.intl  = (k == 2'd0) && ea && (a < 16'h1000);
    it.exp   = it.intl ? rom_val(a[11:0]) : (k == 2'd0) ? code_val(a) :
               (k == 2'd1) ? shadow[a[7:0]] : 8'h00;
    if (k == 2'd2) shadow[a[7:0]] = wd;
    it.start = cyc;
    it.tag   = tag;
    q.push_back(it);
    req_i = 1'b1; kind_i = k; addr_i = a; wdata_i = wd; ea_i = ea;
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk_i) begin
    if (rst_ni && started) begin
      if (!psen_no) c_psen++;
      if (!rd_no) c_rd++;
      if (!wr_no) c_wr++;
      if (ale_o) c_ale++;
      if (rom_en_o) c_rom++;
      if (((!psen_no) + (!rd_no) + (!wr_no)) > 1) multi++;
      if (!rd_no && ad_oe_o) rd_drive++;
      if (q.size() > 0) begin
        if ((ale_o || !psen_no || !rd_no || !wr_no) && addr_hi_o !== q[0].addr[15:8]) hi_bad++;
        if (ale_o && (ad_o !== q[0].addr[7:0] || !ad_oe_o)) lo_bad++;
      end
      if (done_o) begin
        if (q.size() == 0) check("R10 unexpected done", 1, 0);
        else begin
          item_t it;
          it = q.pop_front();
          check({"R10 latency ", it.tag}, cyc - it.start, 12);
          check({"R7 one strobe ", it.tag}, multi, 0);
          if (it.intl) begin
            check({"R8 rom enable clocks ", it.tag}, c_rom, 6);
            check({"R8 bus quiet ", it.tag}, c_psen + c_rd + c_wr + c_ale, 0);
            check({"R8 rom data ", it.tag}, rdata_o, it.exp);
          end else begin
            check({"R2 ale clocks ", it.tag}, c_ale, 2);
            check({"R2 low address ", it.tag}, {lo_bad[23:0], lat}, {24'h0, it.addr[7:0]});
            check({"R3 high address ", it.tag}, hi_bad, 0);
            check({"R8 rom idle on bus access ", it.tag}, c_rom, 0);
            case (it.kind)
              2'd0: begin
                check({"R4 psen clocks ", it.tag}, {c_psen[15:0], c_rd[7:0], c_wr[7:0]}, {16'd6, 16'd0});
                check({"R4 code data ", it.tag}, rdata_o, it.exp);
              end
              2'd1: begin
                check({"R5 rd clocks ", it.tag}, {c_rd[15:0], c_psen[7:0], c_wr[7:0]}, {16'd6, 16'd0});
                check({"R5 port released ", it.tag}, rd_drive, 0);
                check({"R5 read data ", it.tag}, rdata_o, it.exp);
              end
              default: begin
                check({"R6 wr clocks ", it.tag}, {c_wr[15:0], c_psen[7:0], c_rd[7:0]}, {16'd6, 16'd0});
              end
            endcase
          end
        end
        c_psen = 0; c_rd = 0; c_wr = 0; c_ale = 0; c_rom = 0;
        multi = 0; rd_drive = 0; hi_bad = 0; lo_bad = 0;
      end
    end
  end

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      dmem[i]   = 8'(i) ^ 8'h77;
      shadow[i] = 8'(i) ^ 8'h77;
    end
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R1 strobes in reset", {psen_no, rd_no, wr_no}, 3'b111);
    check("R1 ale/oe in reset", {ale_o, ad_oe_o}, 2'b00);
    check("R1 ready after reset", ready_o, 1'b1);
    rst_ni = 1'b1;
    started = 1'b1;
    @(negedge clk_i);
    issue(2'd0, 16'h0123, 8'h00, 1'b0, "R4/R9 ea low");
    issue(2'd0, 16'h0ABC, 8'h00, 1'b1, "R8 internal");
    issue(2'd0, 16'h1000, 8'h00, 1'b1, "R9 boundary external");
    issue(2'd0, 16'h0FFF, 8'h00, 1'b1, "R8 boundary internal");
    issue(2'd2, 16'h0042, 8'hA5, 1'b1, "R6/R11 write low");
    issue(2'd1, 16'h0042, 8'h00, 1'b1, "R5/R6/R11 readback");
    issue(2'd2, 16'h80FF, 8'h3C, 1'b0, "R6 write high");
    issue(2'd1, 16'h80FF, 8'h00, 1'b0, "R5/R6 readback high");
    issue(2'd1, 16'h7710, 8'h00, 1'b0, "R5 unwritten");
    issue(2'd0, 16'hFFFF, 8'h00, 1'b1, "R9 top code");
    issue(2'd0, 16'h0000, 8'h00, 1'b1, "R8 zero");
    while (q.size() > 0) @(negedge clk_i);
    @(negedge clk_i);
    check("R10 idle at end", ready_o, 1'b1);
    summary();
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end
endmodule